// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the word-addressed control and status store of a clock control unit. A simple 32-bit bus reaches it: the bus supplies a byte address, a write strobe with write data, and a read strobe. The block returns the read data one cycle later. The register index is the byte address with its two low bits dropped, and the window covers 4 KiB. Only whole, aligned words are accessed.

The bank holds 26 words, and each word loads a fixed value at reset. A few words can be written, each through a mask of its own. The mode word also has one bit that every write sets high. Any other write target leaves all state as it was. These targets are the read-only words, the spare words and indices past the end of the bank. Such a write raises a one-cycle error pulse. A read past the end of the bank returns zero and also raises the error pulse. The mode word and the first divider word drive output ports at all times, and a downstream frequency evaluator uses them.

Top module: `ccr_bank`

## Requirements
- R1: After reset, each register holds its reset word. The index layout is 0 mode 0x074B0B7D, 1 divider-0 0xFF870B48, 2 divider-1 0x49FCFE7F, 3 divider-2 0x00000285, 4 main PLL 0x04001800, 5 USB PLL 0x04051C03, 6 serial PLL 0x04043001, 7 status 0x007F0000, 8 clock-out select 0x00000280, 9 to 11 gating 0xFFFFFFFF, 12 wake mask 0xFFFFFFFF, 13 power-0 0x80209828, 14 power-1 0x00AA0000, 15 to 25 spare 0x00000000.
- R2: A write to index 0 stores (data AND 0x3B6FDFFF) OR 0x00000004. Bit 2 is therefore always 1 after any write.
- R3: A write to index 1 stores data AND 0xFF9F3FFF.
- R4: A write to index 4 or to index 6 stores data AND 0xBFFF3FFF.
- R5: A write to index 2, 9, 10 or 11 stores all 32 data bits.
- R6: A write to any other index leaves every register unchanged and raises bus_err for one cycle. This includes indices 3, 5, 7, 8 and 12 to 25, and indices of 26 and above.
- R7: A read of index 0 to 25 returns that register's current value on bus_rdata in the cycle after the read strobe is sampled, with bus_err low.
- R8: A read of index 26 or above returns zero and raises bus_err in the cycle after the strobe.
- R9: mode_out always equals register 0, and div0_out always equals register 1.
- R10: bus_rdata is zero and bus_err is low in any cycle that follows a cycle with no faulting access and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address; bits 11:2 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle error pulse aligned with the response |
| mode_out | output | 32 | Live copy of the mode register |
| div0_out | output | 32 | Live copy of divider register 0 |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 26 registers. With that address width, the bench can reach index 1023, the highest index, as well as the boundary between index 25 and index 26. Random reads and writes are spread over indices 0 to 31 and a handful of high indices. This exercises every mask, the forced bit and both error paths against a bench model. Directed writes with all-ones and all-zeros data expose each masked bit.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int DATA_W = 32;

    localparam int IX_MODE   = 0;
    localparam int IX_DIV0   = 1;
    localparam int IX_DIV1   = 2;
    localparam int IX_PLL_M  = 4;
    localparam int IX_PLL_S  = 6;
    localparam int IX_GATE0  = 9;
    localparam int IX_GATE2  = 11;

    localparam logic [DATA_W-1:0] MODE_FORCE = 32'h0000_0004;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rsp_t;

    function automatic logic [DATA_W-1:0] reset_word(int i);
        case (i)
            0:       reset_word = 32'h074B_0B7D;
            1:       reset_word = 32'hFF87_0B48;
            2:       reset_word = 32'h49FC_FE7F;
            3:       reset_word = 32'h0000_0285;
            4:       reset_word = 32'h0400_1800;
            5:       reset_word = 32'h0405_1C03;
            6:       reset_word = 32'h0404_3001;
            7:       reset_word = 32'h007F_0000;
            8:       reset_word = 32'h0000_0280;
            9, 10, 11, 12: reset_word = 32'hFFFF_FFFF;
            13:      reset_word = 32'h8020_9828;
            14:      reset_word = 32'h00AA_0000;
            default: reset_word = '0;
        endcase
    endfunction

    function automatic logic is_writable(int i);
        is_writable = (i == IX_MODE) || (i == IX_DIV0) || (i == IX_DIV1) ||
                      (i == IX_PLL_M) || (i == IX_PLL_S) ||
                      (i >= IX_GATE0 && i <= IX_GATE2);
    endfunction

    function automatic logic [DATA_W-1:0] write_mask(int i);
        case (i)
            IX_MODE:            write_mask = 32'h3B6F_DFFF;
            IX_DIV0:            write_mask = 32'hFF9F_3FFF;
            IX_PLL_M, IX_PLL_S: write_mask = 32'hBFFF_3FFF;
            IX_DIV1, 9, 10, 11: write_mask = 32'hFFFF_FFFF;
            default:            write_mask = '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] force_bits(int i);
        force_bits = (i == IX_MODE) ? MODE_FORCE : '0;
    endfunction
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 26,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic [IDX_W-1:0] idx,
    output logic             in_range,
    output logic             writable
);
    always_comb begin
        in_range = (32'(idx) < NUM_REGS);
        writable = in_range && ccr_pkg::is_writable(int'(32'(idx)));
    end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile #(
    parameter int NUM_REGS = 26,
    parameter int IDX_W    = 10,
    localparam int DW      = ccr_pkg::DATA_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DW-1:0]                wdata,
    output logic [NUM_REGS-1:0][DW-1:0]  regs_o
);
    logic [NUM_REGS-1:0][DW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                regs_d[i] = (wdata & ccr_pkg::write_mask(i)) | ccr_pkg::force_bits(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= ccr_pkg::reset_word(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/ccr_bank.sv
module ccr_bank #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 26,
    localparam int IDX_W   = ADDR_W - 2,
    localparam int DW      = ccr_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    output logic [DW-1:0]     mode_out,
    output logic [DW-1:0]     div0_out
);
    logic [IDX_W-1:0]            idx;
    logic                        in_range, writable;
    logic [NUM_REGS-1:0][DW-1:0] regs;
    logic                        unused_low;
    ccr_pkg::rsp_t               rsp_d, rsp_q;

    assign idx        = bus_addr[ADDR_W-1:2];
    assign unused_low = &{1'b0, bus_addr[1:0]};

    ccr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) dec_i (
        .idx(idx), .in_range(in_range), .writable(writable)
    );

    ccr_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) rf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && writable),
        .wr_idx(idx), .wdata(bus_wdata), .regs_o(regs)
    );

    always_comb begin
        rsp_d = '0;
        if (bus_rd) begin
            if (in_range) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (idx == IDX_W'(i)) rsp_d.rdata = regs[i];
                end
            end else begin
                rsp_d.err = 1'b1;
            end
        end
        if (bus_wr && !writable) rsp_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rdata = rsp_q.rdata;
    assign bus_err   = rsp_q.err;
    assign mode_out  = regs[ccr_pkg::IX_MODE];
    assign div0_out  = regs[ccr_pkg::IX_DIV0];
endmodule

// File: rtl/ccr_bank_chk.sv
module ccr_bank_chk #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 26,
    localparam int IDX_W   = ADDR_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [31:0]       mode_out,
    input logic [31:0]       div0_out
);
    logic [IDX_W-1:0] cidx;
    logic             past_end;
    assign cidx     = bus_addr[ADDR_W-1:2];
    assign past_end = (32'(cidx) >= NUM_REGS);

    assert_force_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cidx == IDX_W'(0)) |=> mode_out[2]);

    assert_div0_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cidx == IDX_W'(1)) |=> div0_out == ($past(bus_wdata) & 32'hFF9F_3FFF));

    assert_foreign_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cidx != IDX_W'(0)) |=> $stable(mode_out));

    assert_oor_write_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && past_end) |=> bus_err);

    assert_oor_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && past_end) |=> (bus_err && bus_rdata == 32'h0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> (!bus_err && bus_rdata == 32'h0));
endmodule

bind ccr_bank ccr_bank_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) chk_i (.*);

// File: tb/ccr_bank_tb.sv
module ccr_bank_tb_top;
    localparam int NREG = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, mode_out, div0_out;
    logic        bus_err;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] model [NREG];

    always #5 clk = ~clk;

    ccr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .mode_out(mode_out), .div0_out(div0_out)
    );

    function automatic logic [31:0] m_rst(int i);
        case (i)
            0: return 32'h074B0B7D;  1: return 32'hFF870B48;
            2: return 32'h49FCFE7F;  3: return 32'h00000285;
            4: return 32'h04001800;  5: return 32'h04051C03;
            6: return 32'h04043001;  7: return 32'h007F0000;
            8: return 32'h00000280;  9, 10, 11, 12: return 32'hFFFFFFFF;
            13: return 32'h80209828; 14: return 32'h00AA0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_wr_ok(int i);
        return i == 0 || i == 1 || i == 2 || i == 4 || i == 6 || (i >= 9 && i <= 11);
    endfunction

    function automatic logic [31:0] m_store(int i, logic [31:0] d);
        case (i)
            0:       return (d & 32'h3B6FDFFF) | 32'h4;
            1:       return d & 32'hFF9F3FFF;
            4, 6:    return d & 32'hBFFF3FFF;
            default: return d;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(int idx, logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (idx < NREG && m_wr_ok(idx)) begin
            model[idx] = m_store(idx, d);
            check("R10 err on good write", 32'(bus_err), 32'h0);
        end else begin
            check("R6 err on ignored write", 32'(bus_err), 32'h1);
        end
        check("R9 mode_out", mode_out, model[0]);
        check("R9 div0_out", div0_out, model[1]);
    endtask

    task automatic do_rd(int idx, string tag);
        @(negedge clk);
        bus_addr = 12'(idx << 2); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        if (idx < NREG) begin
            check(tag, bus_rdata, model[idx]);
            check("R7 err low", 32'(bus_err), 32'h0);
        end else begin
            check("R8 rdata zero", bus_rdata, 32'h0);
            check("R8 err", 32'(bus_err), 32'h1);
        end
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);
        check("R10 idle err", 32'(bus_err), 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) model[i] = m_rst(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mode_out", mode_out, 32'h074B0B7D);
        check("R10 reset err", 32'(bus_err), 32'h0);
        for (int i = 0; i < NREG; i++) do_rd(i, "R1 reset value");
        // R2: forced bit and mask
        do_wr(0, 32'hFFFFFFFF); do_rd(0, "R2 all ones");
        do_wr(0, 32'h0);        do_rd(0, "R2 zero forces bit 2");
        check("R2 mode_out", mode_out, 32'h4);
        // R3, R4, R5
        do_wr(1, 32'hFFFFFFFF); do_rd(1, "R3 div0 mask");
        do_wr(4, 32'hFFFFFFFF); do_rd(4, "R4 main pll mask");
        do_wr(6, 32'hFFFFFFFF); do_rd(6, "R4 serial pll mask");
        do_wr(2, 32'hA5A5_5A5A); do_rd(2, "R5 div1 full");
        do_wr(9, 32'h1234_5678); do_rd(9, "R5 gate0 full");
        do_wr(11, 32'h0);       do_rd(11, "R5 gate2 full");
        // R6: ignored writes
        do_wr(7, 32'h0);  do_rd(7, "R6 status unchanged");
        do_wr(5, 32'h0);  do_rd(5, "R6 usb pll unchanged");
        do_wr(3, 32'h0);  do_rd(3, "R6 div2 unchanged");
        do_wr(25, 32'hFFFFFFFF); do_rd(25, "R6 spare unchanged");
        do_wr(26, 32'hFFFFFFFF); do_wr(1023, 32'hFFFFFFFF);
        // R8 boundaries
        do_rd(26, "R8"); do_rd(1023, "R8");
        // random mix
        for (int n = 0; n < 400; n++) begin
            int idx;
            idx = ($urandom % 8 == 0) ? int'($urandom % 1024) : int'($urandom % 32);
            if ($urandom % 2 == 0) do_wr(idx, $urandom);
            else                   do_rd(idx, "R7 random read");
        end
        for (int i = 0; i < NREG; i++) do_rd(i, "R7 final sweep");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule